// File: doc/BRIEF.md
# Suspend Modulation Pulse Generator

This block throttles a processor by toggling an active-low suspend line. While throttling is enabled, the line is driven low (the processor idles with its core clock stopped) for a programmed number of base intervals. It is then released (the processor runs) for another programmed number of intervals, and this repeats. One base interval is 32 µs and is made from the system clock by a parameterised divider. The fraction of time the processor runs, OFF / (OFF + ON), sets its effective rate.

A small byte-wide register file is written and read through a plain strobe interface. It holds the two interval counts, a configuration byte whose bit 0 enables throttling, and a power-management enable byte. Two retriggerable speedup timers, one for interrupts and one for video activity, stop throttling for a programmed number of milliseconds after each event. Throttling resumes once the timer runs out.

New interval counts are taken up only at a phase boundary, so a phase that is running is never cut short or stretched. Every phase starts on a base-interval tick.

Top module: `susp_mod_gen`

## Requirements
- R1: After a synchronous active-high reset, `susp_n` is 1 and every register reads 0.
- R2: Registers are at these addresses: 0x80 power-management enable, 0x8C interrupt speedup count, 0x8D video speedup count, 0x94 OFF count, 0x95 ON count, 0x96 configuration. Each reads back the last byte written to it. Any other address reads 0, and a write to it changes nothing.
- R3: While configuration bit 0 is 0, `susp_n` stays 1 whatever the counts are.
- R4: With configuration bit 0 set and no speedup active, `susp_n` is 0 for ON × CLKS_PER_TICK clocks, then 1 for OFF × CLKS_PER_TICK clocks, repeating.
- R5: A phase whose count is 0 is skipped. With ON = 0 and OFF ≠ 0, `susp_n` stays 1. With OFF = 0 and ON ≠ 0, it stays 0 once the first phase has started.
- R6: With both counts 0, `susp_n` stays 1 even when throttling is enabled.
- R7: ON or OFF values written during a phase do not change the length of that phase. They take effect from the next phase that uses them.
- R8: While throttling stays enabled, `susp_n` changes only on the clock after a base-interval tick.
- R9: With enable bit 3 set, an `irq_event` pulse forces `susp_n` to 1 from the second clock after it. This lasts count × TICKS_PER_MS ticks (±1 ms). Each new pulse restarts the timer. Afterwards the first phase is a full ON phase.
- R10: With enable bit 4 set, a `vid_event` pulse suspends throttling in the same way, using the video speedup count.
- R11: A speedup event has no effect when its enable bit is 0 or its count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq_event | input | 1 | Interrupt activity pulse |
| vid_event | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the processor |

## Verification
The assertions check on every cycle that the line is released while throttling is disabled or a speedup timer is running. They also check that it never changes between ticks while throttling stays on, that an asserted phase starts only when the ON count is non-zero, and that a speedup timer starts only from an armed event. The exact phase lengths, the deferred take-up of new counts, the retrigger of a speedup window and the full-length first phase after it can only be shown by the bench's scenarios. The bench does this by timing runs of the output level.

// File: rtl/susp_mod_pkg.sv
package susp_mod_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SPD = 2;

    typedef logic [REG_W-1:0] byte_t;

    localparam byte_t ADR_PME     = 8'h80;
    localparam byte_t ADR_IRQ_MS  = 8'h8C;
    localparam byte_t ADR_VID_MS  = 8'h8D;
    localparam byte_t ADR_OFF     = 8'h94;
    localparam byte_t ADR_ON      = 8'h95;
    localparam byte_t ADR_CFG     = 8'h96;

    localparam int CFG_EN_BIT  = 0;
    localparam int PME_IRQ_BIT = 3;
    localparam int PME_VID_BIT = 4;

    typedef enum logic [1:0] {PH_IDLE, PH_ON, PH_OFF} phase_e;

    typedef struct packed {
        byte_t pme;
        byte_t irq_ms;
        byte_t vid_ms;
        byte_t off_cnt;
        byte_t on_cnt;
        byte_t cfg;
    } regs_t;

    // Choose the next phase, preferring 'pref' and skipping zero counts.
    function automatic phase_e pick_phase(phase_e pref, byte_t on_c, byte_t off_c);
        if (pref == PH_OFF) begin
            if (off_c != '0) return PH_OFF;
            if (on_c  != '0) return PH_ON;
        end else begin
            if (on_c  != '0) return PH_ON;
            if (off_c != '0) return PH_OFF;
        end
        return PH_IDLE;
    endfunction
endpackage

// File: rtl/susp_tick_gen.sv
module susp_tick_gen #(
    parameter int CLKS_PER_TICK = 4000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [W-1:0] LAST = W'(CLKS_PER_TICK - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/susp_regs.sv
module susp_regs
    import susp_mod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t addr,
    input  byte_t wr_data,
    output byte_t rd_data,
    output regs_t regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_PME:    regs.pme     <= wr_data;
                ADR_IRQ_MS: regs.irq_ms  <= wr_data;
                ADR_VID_MS: regs.vid_ms  <= wr_data;
                ADR_OFF:    regs.off_cnt <= wr_data;
                ADR_ON:     regs.on_cnt  <= wr_data;
                ADR_CFG:    regs.cfg     <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADR_PME:    rd_data = regs.pme;
            ADR_IRQ_MS: rd_data = regs.irq_ms;
            ADR_VID_MS: rd_data = regs.vid_ms;
            ADR_OFF:    rd_data = regs.off_cnt;
            ADR_ON:     rd_data = regs.on_cnt;
            ADR_CFG:    rd_data = regs.cfg;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/susp_speedup_timer.sv
module susp_speedup_timer
    import susp_mod_pkg::*;
#(
    parameter int TICKS_PER_MS = 31
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  arm_en,
    input  logic  trigger,
    input  byte_t load_ms,
    output logic  active
);
    localparam int SW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [SW-1:0] SLAST = SW'(TICKS_PER_MS - 1);

    byte_t         ms_left;
    logic [SW-1:0] sub;

    assign active = (ms_left != '0);

    always_ff @(posedge clk) begin
        if (rst || !arm_en) begin
            ms_left <= '0;
            sub     <= '0;
        end else if (trigger) begin
            ms_left <= load_ms;
            sub     <= '0;
        end else if (tick && active) begin
            if (sub == SLAST) begin
                sub     <= '0;
                ms_left <= ms_left - 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/susp_phase_engine.sv
module susp_phase_engine
    import susp_mod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  mod_en,
    input  byte_t on_cnt,
    input  byte_t off_cnt,
    output logic  susp_n
);
    phase_e state;
    phase_e nxt;
    byte_t  left;
    logic   boundary;

    assign boundary = (state == PH_IDLE) || (left == 8'd1);
    assign nxt      = pick_phase((state == PH_ON) ? PH_OFF : PH_ON, on_cnt, off_cnt);
    assign susp_n   = (state != PH_ON);

    always_ff @(posedge clk) begin
        if (rst || !mod_en) begin
            state <= PH_IDLE;
            left  <= '0;
        end else if (tick) begin
            if (boundary) begin
                state <= nxt;
                left  <= (nxt == PH_ON)  ? on_cnt :
                         (nxt == PH_OFF) ? off_cnt : '0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/susp_mod_gen.sv
module susp_mod_gen
    import susp_mod_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4000,
    parameter int TICKS_PER_MS  = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       irq_event,
    input  logic       vid_event,
    output logic       susp_n
);
    regs_t               regs;
    logic                base_tick;
    logic                cfg_en;
    logic                mod_en;
    byte_t               on_cnt;
    logic [NUM_SPD-1:0]  spd_arm;
    logic [NUM_SPD-1:0]  spd_evt;
    logic [NUM_SPD-1:0]  spd_trig;
    logic [NUM_SPD-1:0]  spd_active;
    byte_t               spd_ms [NUM_SPD];

    susp_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst(rst), .tick(base_tick)
    );

    susp_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .regs(regs)
    );

    assign spd_arm   = {regs.pme[PME_VID_BIT], regs.pme[PME_IRQ_BIT]};
    assign spd_evt   = {vid_event, irq_event};
    assign spd_trig  = spd_evt & spd_arm;
    assign spd_ms[0] = regs.irq_ms;
    assign spd_ms[1] = regs.vid_ms;

    for (genvar i = 0; i < NUM_SPD; i++) begin : g_spd
        susp_speedup_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_tmr (
            .clk(clk), .rst(rst), .tick(base_tick), .arm_en(spd_arm[i]),
            .trigger(spd_trig[i]), .load_ms(spd_ms[i]), .active(spd_active[i])
        );
    end

    assign cfg_en = regs.cfg[CFG_EN_BIT];
    assign mod_en = cfg_en && (spd_active == '0);
    assign on_cnt = regs.on_cnt;

    susp_phase_engine u_eng (
        .clk(clk), .rst(rst), .tick(base_tick), .mod_en(mod_en),
        .on_cnt(on_cnt), .off_cnt(regs.off_cnt), .susp_n(susp_n)
    );
endmodule

// File: rtl/susp_mod_checker.sv
module susp_mod_checker (
    input logic       clk,
    input logic       rst,
    input logic       susp_n,
    input logic       tick,
    input logic       cfg_en,
    input logic       mod_en,
    input logic [7:0] on_cnt,
    input logic [1:0] spd_trig,
    input logic [1:0] spd_active
);
    AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> susp_n); // R3

    AST_SPEEDUP_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (spd_active != 2'b00) |=> susp_n); // R9

    AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(mod_en) && !$past(tick)) |-> $stable(susp_n)); // R8

    AST_ON_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        $fell(susp_n) |-> ($past(on_cnt) != 8'd0)); // R5

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(spd_active[0]) |-> $past(spd_trig[0])); // R11

    AST_VID_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(spd_active[1]) |-> $past(spd_trig[1])); // R10
endmodule

bind susp_mod_gen susp_mod_checker u_chk (
    .clk(clk), .rst(rst), .susp_n(susp_n), .tick(base_tick),
    .cfg_en(cfg_en), .mod_en(mod_en), .on_cnt(on_cnt),
    .spd_trig(spd_trig), .spd_active(spd_active)
);

// File: tb/susp_mod_gen_bench.sv
module susp_mod_gen_bench;
    localparam int CPT = 4;
    localparam int TPM = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_event = 1'b0;
    logic       vid_event = 1'b0;
    logic       susp_n;

    int n_chk = 0;
    int n_bad = 0;

    susp_mod_gen #(.CLKS_PER_TICK(CPT), .TICKS_PER_MS(TPM)) u_susp_mod_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_event(irq_event), .vid_event(vid_event),
        .susp_n(susp_n)
    );

    always #4 clk = ~clk;

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL [watchdog] actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL [%s] actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk); addr = a; #1; v = rd_data;
    endtask

    task automatic set_mod(input logic [7:0] on_c, input logic [7:0] off_c,
                           input logic [7:0] cfg);
        wr(8'h95, on_c); wr(8'h94, off_c); wr(8'h96, cfg);
    endtask

    task automatic wait_for(input logic lvl);
        for (int g = 0; g < 3000 && susp_n != lvl; g++) @(negedge clk);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (susp_n == lvl && n < 3000) begin n++; @(negedge clk); end
    endtask

    task automatic hold_bad(input logic lvl, input int cycles, output int bad);
        bad = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (susp_n != lvl) bad++;
        end
    endtask

    task automatic pulse(input bit vid);
        @(negedge clk); if (vid) vid_event = 1'b1; else irq_event = 1'b1;
        @(negedge clk); vid_event = 1'b0; irq_event = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        @(negedge clk);
        chk("R1 susp_n after reset", susp_n, 1);
        rd(8'h94, v); chk("R1 off reg", v, 0);
        rd(8'h95, v); chk("R1 on reg", v, 0);
        rd(8'h96, v); chk("R1 cfg reg", v, 0);
        rd(8'h80, v); chk("R1 pme reg", v, 0);
    endtask

    task automatic t_regs();
        int v;
        wr(8'h80, 8'h18); wr(8'h8C, 8'h04); wr(8'h8D, 8'h64);
        wr(8'h94, 8'h05); wr(8'h95, 8'h03); wr(8'h96, 8'h00);
        wr(8'h90, 8'hAA);
        rd(8'h80, v); chk("R2 pme readback", v, 8'h18);
        rd(8'h8C, v); chk("R2 irq count readback", v, 4);
        rd(8'h8D, v); chk("R2 vid count readback", v, 100);
        rd(8'h94, v); chk("R2 off readback", v, 5);
        rd(8'h95, v); chk("R2 on readback", v, 3);
        rd(8'h90, v); chk("R2 unmapped reads zero", v, 0);
        rd(8'h96, v); chk("R2 cfg untouched by unmapped write", v, 0);
        wr(8'h80, 8'h00);
    endtask

    task automatic t_disabled();
        int bad;
        set_mod(8'd3, 8'd5, 8'h00);
        hold_bad(1'b1, 150, bad); chk("R3 disabled stays released", bad, 0);
    endtask

    task automatic t_duty(input int on_c, input int off_c);
        int lo, hi, lo2;
        set_mod(8'(on_c), 8'(off_c), 8'h01);
        wait_for(1'b1); wait_for(1'b0);
        run_len(1'b0, lo); run_len(1'b1, hi); run_len(1'b0, lo2);
        chk("R4 low length", lo, on_c * CPT);
        chk("R4 high length", hi, off_c * CPT);
        chk("R8 repeated low length", lo2, on_c * CPT);
    endtask

    task automatic t_zero_phases();
        int bad;
        set_mod(8'd0, 8'd5, 8'h01);
        hold_bad(1'b1, 150, bad); chk("R5 zero ON stays released", bad, 0);
        set_mod(8'd3, 8'd0, 8'h01);
        wait_for(1'b0);
        hold_bad(1'b0, 150, bad); chk("R5 zero OFF stays asserted", bad, 0);
        set_mod(8'd0, 8'd0, 8'h01);
        wait_for(1'b1);
        hold_bad(1'b1, 150, bad); chk("R6 both zero released", bad, 0);
    endtask

    task automatic t_midcycle();
        int rem, lo, hi;
        set_mod(8'd3, 8'd5, 8'h01);
        wait_for(1'b0); wait_for(1'b1);
        wr(8'h95, 8'd2); wr(8'h94, 8'd1);
        run_len(1'b1, rem); run_len(1'b0, lo); run_len(1'b1, hi);
        chk("R7 running phase kept", rem, 5 * CPT - 4);
        chk("R7 new ON applied", lo, 2 * CPT);
        chk("R7 new OFF applied", hi, 1 * CPT);
    endtask

    task automatic t_speedup(input bit vid, input int ms);
        int hi, bad, lo;
        string tag;
        tag = vid ? "R10" : "R9";
        set_mod(8'd3, 8'd5, 8'h01);
        wr(vid ? 8'h8D : 8'h8C, 8'(ms));
        wr(8'h80, vid ? 8'h10 : 8'h08);
        wait_for(1'b1); wait_for(1'b0);
        pulse(vid);
        @(negedge clk);
        run_len(1'b1, hi);
        chk_rng({tag, " speedup window"}, hi, ms * TPM * CPT - 7, ms * TPM * CPT + 4);
        run_len(1'b0, lo);
        chk({tag, " full ON after speedup"}, lo, 3 * CPT);
        if (!vid) begin
            wait_for(1'b0);
            pulse(vid);
            @(negedge clk);
            hold_bad(1'b1, 16, bad);
            pulse(vid);
            @(negedge clk);
            run_len(1'b1, hi);
            chk("R9 retrigger keeps released", bad, 0);
            chk_rng("R9 retrigger restarts window", hi, ms * TPM * CPT - 7, ms * TPM * CPT + 4);
        end
        wr(8'h80, 8'h00);
    endtask

    task automatic t_ignored();
        int lo, hi;
        set_mod(8'd3, 8'd5, 8'h01);
        wr(8'h8C, 8'd4); wr(8'h80, 8'h00);
        wait_for(1'b1); wait_for(1'b0);
        pulse(1'b0);
        run_len(1'b0, lo); run_len(1'b1, hi);
        chk("R11 disarmed irq ignored low", lo + 2, 3 * CPT);
        chk("R11 disarmed irq ignored high", hi, 5 * CPT);
        wr(8'h8C, 8'd0); wr(8'h80, 8'h08);
        wait_for(1'b1); wait_for(1'b0);
        pulse(1'b0);
        run_len(1'b0, lo);
        chk("R11 zero count irq ignored", lo + 2, 3 * CPT);
        wr(8'h80, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_disabled();
        t_duty(3, 5);
        t_duty(1, 1);
        t_zero_phases();
        t_midcycle();
        t_speedup(1'b0, 4);
        t_speedup(1'b1, 3);
        t_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule